// File: doc/BRIEF.md
# Multi-Channel Compare-Match PWM Timer

This block is a timer with a parameter-set number of independent 16-bit channels, four by default. Each channel drives one PWM pin. It has an up-counter that steps on a prescaled clock. A period register clears the counter when the count reaches it, and a duty register sets the point where the pin changes level. A run register holds one bit per channel and starts or stops each counter on its own. Per-channel control fields select the divide ratio, the output polarity and a pin mode. The pin mode can hold the pin at its inactive or active level instead of the waveform.

Software writes and reads every register over a plain single-cycle register bus. A write completes on the clock edge where `bus_we` is high. A read is combinational from `bus_addr`. The bus has no stall and no back-pressure. Duty writes made while a channel runs are held in a buffer and loaded at the next counter clear. Because of this the duty can be retuned on a live channel without restarting it and without a torn period. A duty of zero, or a duty equal to the period, gives a steady level with no one-count spike.

Top module: `pwmt_timer`

Register map (addresses on `bus_addr`): address 0 is the run register, and bit c runs channel c. Channel c occupies addresses 4*(c+1) to 4*(c+1)+3, as follows:
- offset 0: control.
- offset 1: counter. It is read-only; see R10.
- offset 2: duty.
- offset 3: period.

The control register has three fields:
- bits [1:0] select the divider: 0 for 1, 1 for 4, 2 for 16, 3 for 64.
- bit 2 inverts the polarity.
- bits [4:3] set the pin mode: 0 or 3 for waveform, 1 for forced inactive, 2 for forced active.

The active level is 1 when the invert bit is 0, and 0 when it is 1.

## Requirements
- R1: After reset every pin is 0, every counter is 0, the run register is 0, and all control, duty and period registers read 0.
- R2: While its run bit is 1, a channel's counter increments once every 1, 4, 16 or 64 clocks, as set by control bits [1:0]. Counting starts from the clock after the run bit is set.
- R3: On the step where the counter equals the period register, the counter goes to 0 instead of incrementing.
- R4: With the invert bit at 0, in waveform mode and running, the pin is 1 while counter < duty and 0 otherwise.
- R5: With the invert bit at 1, the levels of R4 are swapped.
- R6: Each run bit controls only its own channel. A stopped channel holds its counter value, and its pin in waveform mode sits at the inactive level.
- R7: Pin mode 1 holds the pin at the inactive level and pin mode 2 holds it at the active level, whether the channel is running or not.
- R8: In waveform mode on a running channel, a duty of 0 gives a steady inactive level, and a duty equal to the period gives a steady active level.
- R9: A duty write to a running channel does not disturb its counter. The new duty is used only from the next counter clear onward. A stopped channel uses a new duty at once.
- R10: The counter register cannot be loaded. A write to it, or to the control register, while the channel is stopped sets the counter to 0. While the channel runs, a counter write is ignored.
- R11: Every register reads back at its address in the map; the duty address returns the last value written. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe, taken on the rising clock edge |
| bus_addr | input | ADDR_W (8) | Register address for writes and reads |
| bus_wdata | input | CNT_W (16) | Write data |
| bus_rdata | output | CNT_W (16) | Read data, combinational from `bus_addr` |
| pwm_out | output | NUM_CH (4) | One PWM pin per channel |

## Verification
The pins are registered, and each one reflects the channel state produced by the same clock edge. A write that lands on edge k therefore shows on the pin right after edge k. A channel with divider 4^s advances its counter on edge k+4^s·n after a start written on edge k. Read data is combinational, so it reflects state as of the last edge. The bench samples pins and read data at the falling edge, half a period after the edge that set them, against a reference model it advances at every rising edge. One directed count uses a hand-derived value: 40 clocks at divide-by-4 gives a count of 10.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

  // pin modes held in control bits [4:3]
  typedef enum logic [1:0] {
    PIN_WAVE     = 2'd0,
    PIN_IDLE     = 2'd1,
    PIN_ACTIVE   = 2'd2,
    PIN_WAVE_ALT = 2'd3
  } pin_mode_e;

  // register offsets inside a channel's four-word window
  localparam logic [1:0] REG_CTRL   = 2'd0;
  localparam logic [1:0] REG_COUNT  = 2'd1;
  localparam logic [1:0] REG_DUTY   = 2'd2;
  localparam logic [1:0] REG_PERIOD = 2'd3;

  // control field layout
  localparam int PSEL_W = 2;
  localparam int CTRL_W = PSEL_W + 3;
  localparam int INV_BIT = PSEL_W;
  localparam int MODE_LSB = PSEL_W + 1;

endpackage

// File: rtl/pwmt_prescaler.sv
module pwmt_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  // ratio is 4**sel, so the divider needs 2*(2**SEL_W - 1) bits
  localparam int DIV_W = 2 * ((1 << SEL_W) - 1);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] lim;

  assign lim  = ~({DIV_W{1'b1}} << (2 * sel));
  assign tick = run && (div_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (!run || restart || tick) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,      // run bit before this edge
  input  logic              run_nx,   // run bit after this edge
  input  logic [CNT_W-1:0]  wdata,
  input  logic              wr_ctrl,
  input  logic              wr_cnt,
  input  logic              wr_duty,
  input  logic              wr_per,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  buf_o,
  output logic [CNT_W-1:0]  duty_o,
  output logic [CNT_W-1:0]  per_o,
  output logic              tick_o,
  output logic              pin_o
);
  logic [PSEL_W-1:0] psel_q, psel_d;
  logic              inv_q, inv_d;
  pin_mode_e         mode_q, mode_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  buf_q, buf_d;
  logic [CNT_W-1:0]  duty_q, duty_d;
  logic [CNT_W-1:0]  per_q, per_d;
  logic              tick, wrap, act, pin_d, pin_q;

  pwmt_prescaler #(.SEL_W(PSEL_W)) u_prescaler (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (wr_ctrl),
    .sel     (psel_q),
    .tick    (tick)
  );

  assign wrap = tick && (cnt_q == per_q);

  always_comb begin
    psel_d = wr_ctrl ? wdata[PSEL_W-1:0] : psel_q;
    inv_d  = wr_ctrl ? wdata[INV_BIT] : inv_q;
    mode_d = wr_ctrl ? pin_mode_e'(wdata[MODE_LSB +: 2]) : mode_q;
    buf_d  = wr_duty ? wdata : buf_q;
    per_d  = wr_per ? wdata : per_q;

    if (!run && (wr_ctrl || wr_cnt)) cnt_d = '0;
    else if (wrap)                   cnt_d = '0;
    else if (tick)                   cnt_d = cnt_q + 1'b1;
    else                             cnt_d = cnt_q;

    // shadowed duty: live copy when stopped, reloaded at each clear when running
    duty_d = (!run || wrap) ? buf_d : duty_q;
  end

  // pin level from the state that this edge produces
  always_comb begin
    act = ~inv_d;
    unique case (mode_d)
      PIN_IDLE:   pin_d = ~act;
      PIN_ACTIVE: pin_d = act;
      default: begin
        if (!run_nx || (duty_d == '0)) pin_d = ~act;
        else if (duty_d == per_d)      pin_d = act;
        else                           pin_d = (cnt_d < duty_d) ? act : ~act;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psel_q <= '0;
      inv_q  <= 1'b0;
      mode_q <= PIN_WAVE;
      cnt_q  <= '0;
      buf_q  <= '0;
      duty_q <= '0;
      per_q  <= '0;
      pin_q  <= 1'b0;
    end else begin
      psel_q <= psel_d;
      inv_q  <= inv_d;
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
      buf_q  <= buf_d;
      duty_q <= duty_d;
      per_q  <= per_d;
      pin_q  <= pin_d;
    end
  end

  assign ctrl_o = {mode_q, inv_q, psel_q};
  assign cnt_o  = cnt_q;
  assign buf_o  = buf_q;
  assign duty_o = duty_q;
  assign per_o  = per_q;
  assign tick_o = tick;
  assign pin_o  = pin_q;
endmodule

// File: rtl/pwmt_timer.sv
module pwmt_timer
  import pwmt_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam int CH_IDX_W = ADDR_W - 2;

  logic [NUM_CH-1:0] start_q, start_d;
  logic              wr_start;

  logic [NUM_CH-1:0][CNT_W-1:0]  cnt_all, buf_all, duty_all, per_all;
  logic [NUM_CH-1:0][CTRL_W-1:0] ctrl_all;
  logic [NUM_CH-1:0][1:0]        mode_all;
  logic [NUM_CH-1:0]             inv_all, tick_all;

  assign wr_start = bus_we && (bus_addr == '0);

  always_comb begin
    start_d = start_q;
    if (wr_start) start_d = bus_wdata[NUM_CH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= '0;
    else        start_q <= start_d;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = bus_we && (bus_addr[ADDR_W-1:2] == CH_IDX_W'(c + 1));

    pwmt_channel #(.CNT_W(CNT_W)) u_channel (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (start_q[c]),
      .run_nx  (start_d[c]),
      .wdata   (bus_wdata),
      .wr_ctrl (hit && (bus_addr[1:0] == REG_CTRL)),
      .wr_cnt  (hit && (bus_addr[1:0] == REG_COUNT)),
      .wr_duty (hit && (bus_addr[1:0] == REG_DUTY)),
      .wr_per  (hit && (bus_addr[1:0] == REG_PERIOD)),
      .ctrl_o  (ctrl_all[c]),
      .cnt_o   (cnt_all[c]),
      .buf_o   (buf_all[c]),
      .duty_o  (duty_all[c]),
      .per_o   (per_all[c]),
      .tick_o  (tick_all[c]),
      .pin_o   (pwm_out[c])
    );

    assign inv_all[c]  = ctrl_all[c][INV_BIT];
    assign mode_all[c] = ctrl_all[c][MODE_LSB +: 2];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == '0) bus_rdata[NUM_CH-1:0] = start_q;
    for (int c = 0; c < NUM_CH; c++) begin
      if (bus_addr[ADDR_W-1:2] == CH_IDX_W'(c + 1)) begin
        unique case (bus_addr[1:0])
          REG_CTRL:  bus_rdata = CNT_W'(ctrl_all[c]);
          REG_COUNT: bus_rdata = cnt_all[c];
          REG_DUTY:  bus_rdata = buf_all[c];
          default:   bus_rdata = per_all[c];
        endcase
      end
    end
  end
endmodule

// File: rtl/pwmt_checker.sv
module pwmt_checker #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           bus_we,
  input logic [NUM_CH-1:0]              start_q,
  input logic [NUM_CH-1:0]              tick_all,
  input logic [NUM_CH-1:0][CNT_W-1:0]   cnt_all,
  input logic [NUM_CH-1:0][CNT_W-1:0]   per_all,
  input logic [NUM_CH-1:0][CNT_W-1:0]   duty_all,
  input logic [NUM_CH-1:0]              inv_all,
  input logic [NUM_CH-1:0][1:0]         mode_all,
  input logic [NUM_CH-1:0]              pwm_out
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    assert_clear_on_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_all[c] && (cnt_all[c] == per_all[c])) |=> (cnt_all[c] == '0))
      else $error("R3 counter did not clear on period match, ch %0d", c);

    assert_hold_when_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_q[c] && !bus_we) |=> $stable(cnt_all[c]))
      else $error("R6 stopped counter moved, ch %0d", c);

    assert_idle_pin_when_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_q[c] && (mode_all[c][1] == mode_all[c][0])) |-> (pwm_out[c] == inv_all[c]))
      else $error("R6 stopped pin not idle, ch %0d", c);

    assert_forced_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_all[c] == 2'b10) |-> (pwm_out[c] == !inv_all[c]))
      else $error("R7 forced active level wrong, ch %0d", c);

    assert_forced_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_all[c] == 2'b01) |-> (pwm_out[c] == inv_all[c]))
      else $error("R7 forced idle level wrong, ch %0d", c);

    assert_zero_duty_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_q[c] && (mode_all[c][1] == mode_all[c][0]) && (duty_all[c] == '0))
        |-> (pwm_out[c] == inv_all[c]))
      else $error("R8 zero duty pin not idle, ch %0d", c);

    assert_duty_held_mid_period_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (start_q[c] && !(tick_all[c] && (cnt_all[c] == per_all[c]))) |=> $stable(duty_all[c]))
      else $error("R9 duty changed mid period, ch %0d", c);
  end
endmodule

bind pwmt_timer pwmt_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_pwmt_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_we   (bus_we),
  .start_q  (start_q),
  .tick_all (tick_all),
  .cnt_all  (cnt_all),
  .per_all  (per_all),
  .duty_all (duty_all),
  .inv_all  (inv_all),
  .mode_all (mode_all),
  .pwm_out  (pwm_out)
);

// File: tb/test_pwmt_timer.sv
module test_pwmt_timer;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 4;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [CNT_W-1:0]  bus_wdata = '0;
  logic [CNT_W-1:0]  bus_rdata;
  logic [NUM_CH-1:0] pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit mon_en = 1'b0;

  pwmt_timer #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_pwmt_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // reference model of the register state
  logic [NUM_CH-1:0] m_start;
  logic [CNT_W-1:0]  m_cnt  [NUM_CH];
  logic [CNT_W-1:0]  m_buf  [NUM_CH];
  logic [CNT_W-1:0]  m_duty [NUM_CH];
  logic [CNT_W-1:0]  m_per  [NUM_CH];
  logic [5:0]        m_div  [NUM_CH];
  logic [1:0]        m_psel [NUM_CH];
  logic [1:0]        m_mode [NUM_CH];
  logic              m_inv  [NUM_CH];

  function automatic logic [ADDR_W-1:0] reg_addr(input int c, input int r);
    return ADDR_W'(4 * (c + 1) + r);
  endfunction

  function automatic logic [5:0] div_limit(input logic [1:0] s);
    case (s)
      2'd0: return 6'd0;
      2'd1: return 6'd3;
      2'd2: return 6'd15;
      default: return 6'd63;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] model_read(input logic [ADDR_W-1:0] a);
    logic [CNT_W-1:0] v;
    v = '0;
    if (a == '0) v[NUM_CH-1:0] = m_start;
    for (int c = 0; c < NUM_CH; c++) begin
      if (a == reg_addr(c, 0)) v = CNT_W'({m_mode[c], m_inv[c], m_psel[c]});
      if (a == reg_addr(c, 1)) v = m_cnt[c];
      if (a == reg_addr(c, 2)) v = m_buf[c];
      if (a == reg_addr(c, 3)) v = m_per[c];
    end
    return v;
  endfunction

  function automatic logic exp_pin(input int c);
    logic act;
    act = ~m_inv[c];
    if (m_mode[c] == 2'b01) return ~act;
    if (m_mode[c] == 2'b10) return act;
    if (!m_start[c] || (m_duty[c] == '0)) return ~act;
    if (m_duty[c] == m_per[c]) return act;
    return (m_cnt[c] < m_duty[c]) ? act : ~act;
  endfunction

  function automatic string pin_tag(input int c);
    if (m_mode[c] == 2'b01 || m_mode[c] == 2'b10) return "R7";
    if (!m_start[c]) return "R6";
    if (m_duty[c] == '0 || m_duty[c] == m_per[c]) return "R8";
    if (m_inv[c]) return "R5";
    return "R4";
  endfunction

  always @(posedge clk or negedge rst_n) begin : model_step
    logic run, tick, wrap, wc, wn, wd, wp;
    if (!rst_n) begin
      m_start = '0;
      for (int c = 0; c < NUM_CH; c++) begin
        m_cnt[c] = '0; m_buf[c] = '0; m_duty[c] = '0; m_per[c] = '0;
        m_div[c] = '0; m_psel[c] = '0; m_mode[c] = '0; m_inv[c] = 1'b0;
      end
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        run  = m_start[c];
        wc   = bus_we && (bus_addr == reg_addr(c, 0));
        wn   = bus_we && (bus_addr == reg_addr(c, 1));
        wd   = bus_we && (bus_addr == reg_addr(c, 2));
        wp   = bus_we && (bus_addr == reg_addr(c, 3));
        tick = run && (m_div[c] == div_limit(m_psel[c]));
        wrap = tick && (m_cnt[c] == m_per[c]);
        m_div[c] = (!run || tick || wc) ? 6'd0 : m_div[c] + 6'd1;
        if (wd) m_buf[c] = bus_wdata;
        if (wp) m_per[c] = bus_wdata;
        if (!run && (wc || wn)) m_cnt[c] = '0;
        else if (wrap)          m_cnt[c] = '0;
        else if (tick)          m_cnt[c] = m_cnt[c] + 1'b1;
        if (!run || wrap) m_duty[c] = m_buf[c];
        if (wc) begin
          m_psel[c] = bus_wdata[1:0];
          m_inv[c]  = bus_wdata[2];
          m_mode[c] = bus_wdata[4:3];
        end
      end
      if (bus_we && bus_addr == '0) m_start = bus_wdata[NUM_CH-1:0];
    end
  end

  task automatic check(input string tag, input logic [CNT_W-1:0] got, input logic [CNT_W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // every cycle: each pin against the model
  always @(negedge clk) begin
    if (mon_en && !done) begin
      for (int c = 0; c < NUM_CH; c++) begin
        checks++;
        if (pwm_out[c] !== exp_pin(c)) begin
          errors++;
          $display("FAIL %s: ch%0d pin got %b expected %b at %0t",
                   pin_tag(c), c, pwm_out[c], exp_pin(c), $time);
        end
      end
    end
  end

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [CNT_W-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [CNT_W-1:0] v);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic rd_model(input logic [ADDR_W-1:0] a, input string tag);
    logic [CNT_W-1:0] v;
    rd(a, v);
    check(tag, v, model_read(a));
  endtask

  task automatic rd_hard(input logic [ADDR_W-1:0] a, input string tag, input logic [CNT_W-1:0] exp);
    logic [CNT_W-1:0] v;
    rd(a, v);
    check(tag, v, exp);
    check(tag, v, model_read(a));
  endtask

  task automatic pin_window(input int n, input int c, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(tag, CNT_W'(pwm_out[c]), CNT_W'(exp_pin(c)));
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [CNT_W-1:0] a0, a1, v;
    void'($urandom(32'd1234));
    idle(3);
    rst_n = 1'b1;
    mon_en = 1'b1;

    // R1: reset state
    @(negedge clk);
    check("R1", CNT_W'(pwm_out), '0);
    rd_hard('0, "R1", '0);
    rd_hard(reg_addr(0, 1), "R1", '0);
    rd_hard(reg_addr(2, 0), "R1", '0);
    rd_hard(reg_addr(3, 3), "R1", '0);

    // R11: register readback and unmapped address
    wr(reg_addr(1, 3), 16'h1234);
    wr(reg_addr(1, 2), 16'h0042);
    wr(reg_addr(1, 0), 16'h0006);
    rd_hard(reg_addr(1, 3), "R11", 16'h1234);
    rd_hard(reg_addr(1, 2), "R11", 16'h0042);
    rd_hard(reg_addr(1, 0), "R11", 16'h0006);
    rd_hard(8'hF0, "R11", '0);
    wr(reg_addr(1, 0), 16'h0000);

    // R2: divide by 4, 40 clocks after start gives a count of 10
    wr(reg_addr(0, 3), 16'd1000);
    wr(reg_addr(0, 2), 16'd500);
    wr(reg_addr(0, 0), 16'h0001);
    wr('0, 16'h0001);
    idle(39);
    rd_hard(reg_addr(0, 1), "R2", 16'd10);

    // R6: stop holds the counter; other channels untouched
    wr('0, 16'h0000);
    rd(reg_addr(0, 1), a0);
    idle(20);
    rd(reg_addr(0, 1), a1);
    check("R6", a1, a0);
    rd_model(reg_addr(0, 1), "R6");

    // R10: control write while stopped clears counter; count write also clears
    wr(reg_addr(0, 0), 16'h0000);
    rd_hard(reg_addr(0, 1), "R10", '0);
    wr(reg_addr(0, 3), 16'd5);
    wr(reg_addr(0, 2), 16'd2);
    wr('0, 16'h0001);
    idle(3);
    wr(reg_addr(0, 1), 16'hABCD);          // ignored while running
    rd_model(reg_addr(0, 1), "R10");

    // R3: count stays within 0..period and wraps
    for (int i = 0; i < 12; i++) begin
      rd(reg_addr(0, 1), v);
      check("R3", CNT_W'(v <= 16'd5), 16'd1);
      check("R3", v, model_read(reg_addr(0, 1)));
    end

    // R4, R5: normal on ch0, inverted on ch1, both running
    wr(reg_addr(1, 3), 16'd7);
    wr(reg_addr(1, 2), 16'd3);
    wr(reg_addr(1, 0), 16'h0004);
    wr('0, 16'h0003);
    pin_window(12, 0, "R4");
    pin_window(12, 1, "R5");

    // R9: duty change on a running channel, at the next clear only
    wr(reg_addr(0, 2), 16'd4);
    rd_hard(reg_addr(0, 2), "R9", 16'd4);
    rd_model(reg_addr(0, 1), "R9");
    pin_window(14, 0, "R9");

    // R7: forced levels on a stopped channel 2
    wr(reg_addr(2, 0), 16'h0010);
    @(negedge clk);
    check("R7", CNT_W'(pwm_out[2]), 16'd1);
    wr(reg_addr(2, 0), 16'h000C);
    @(negedge clk);
    check("R7", CNT_W'(pwm_out[2]), 16'd1);
    wr(reg_addr(2, 0), 16'h0014);
    @(negedge clk);
    check("R7", CNT_W'(pwm_out[2]), 16'd0);
    wr(reg_addr(2, 0), 16'h0000);

    // R8: zero duty and full duty on running channel 3
    wr(reg_addr(3, 3), 16'd8);
    wr(reg_addr(3, 2), 16'd0);
    wr('0, 16'h000B);
    pin_window(10, 3, "R8");
    check("R8", CNT_W'(pwm_out[3]), 16'd0);
    wr(reg_addr(3, 2), 16'd8);
    idle(12);
    pin_window(12, 3, "R8");
    check("R8", CNT_W'(pwm_out[3]), 16'd1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int c, r;
      logic [CNT_W-1:0] d;
      c = int'($urandom % NUM_CH);
      r = int'($urandom % 4);
      case ($urandom % 10)
        0: wr('0, CNT_W'($urandom % 16));
        1, 2: begin
          case (r)
            0: begin
              d = CNT_W'($urandom % 32);
              if ($urandom % 4 != 0) d[4:3] = 2'b00;
              if ($urandom % 2 != 0) d[1:0] = 2'b00;
            end
            1: d = CNT_W'($urandom);
            2: d = CNT_W'($urandom % (int'(m_per[c]) + 3));
            default: d = CNT_W'($urandom % 24);
          endcase
          wr(reg_addr(c, r), d);
        end
        3: rd_model(reg_addr(c, r), "R11");
        default: idle(1);
      endcase
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule